// File: doc/BRIEF.md
# Prioritized UART Interrupt Controller

This block is the interrupt section of one serial channel. It gathers four interrupt sources: line errors, received data waiting, transmit holding register empty and modem status changes. Each source is gated by its bit in an enable register. The highest-ranked source that is both pending and enabled is reported as a code in an 8-bit status byte, and the channel interrupt request is driven while any such source exists. The serial datapath and the bus decoding sit outside the block and are out of scope. The datapath supplies error and modem-change event pulses, the receive-full and transmit-empty levels, and one strobe for each register access that acknowledges a source.

Line errors and modem changes are held in sticky pending latches. The latch sets on an event pulse and clears on the access that services that source. The receive source follows the receive-full level directly. The transmit source is armed by an empty event. It is dropped by a write to the transmit holding register, or by a status read made while it is the source being reported. A status read never acknowledges any other source.

Top module: `uart_irq_prio`

## Requirements
- R1: After reset the status byte is 0x01, the interrupt request is low and the enable readback is 0x00.
- R2: A write to the enable register stores the four enable bits (bit 0 receive, bit 1 transmit empty, bit 2 line status, bit 3 modem status); readback bits 7:4 are always 0.
- R3: Among enabled pending sources the reported one is chosen by the fixed ranking line status > receive data > transmit empty > modem status, coded in status bits 3:0 as 0110, 0100, 0010, 0000 respectively.
- R4: Status bit 0 is 1 exactly when no enabled source is pending; status bits 7:4 are always 0.
- R5: A source whose enable bit is 0 is not reported. A sticky source (line or modem) that occurred while disabled is still pending, and it is reported as soon as its enable bit is set.
- R6: Any line-error event pulse makes the line source pending; a line-status read clears it, and a status read does not.
- R7: The receive source is pending for exactly as long as the receive-full input is high.
- R8: The transmit source arms on a rising edge of transmit-empty, or on an enable write that sets bit 1 from 0 while transmit-empty is high; a transmit holding write clears it.
- R9: A status read clears the transmit source only when the transmit source is the one reported in that cycle; otherwise it stays pending and shows on a later read.
- R10: Any modem-delta event pulse makes the modem source pending; a modem-status read clears it.
- R11: The interrupt request is the inverse of status bit 0.
- R12: When an event and the clearing access for the same source arrive in the same cycle, the source remains pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_wr | input | 1 | Enable register write strobe |
| en_wdata | input | 4 | Enable bits to write |
| en_rdata | output | 8 | Enable register readback, bits 7:4 zero |
| line_err_evt | input | 4 | One-cycle pulses for overrun, parity, framing and break errors |
| rx_full | input | 1 | Receive holding register holds a character |
| tx_empty | input | 1 | Transmit holding register is empty |
| modem_delta_evt | input | 4 | One-cycle pulses for modem input changes |
| isr_rd | input | 1 | Status register read strobe |
| lsr_rd | input | 1 | Line status register read strobe |
| msr_rd | input | 1 | Modem status register read strobe |
| thr_wr | input | 1 | Transmit holding register write strobe |
| status | output | 8 | Interrupt status byte |
| irq | output | 1 | Interrupt request, active high |

## Verification
Several rules are checked by the assertions on every cycle. Status bits 7:4 stay zero. At most one source wins the ranking. The request matches the set of enabled pending sources. Each clearing access drops its own source, and a status read spares the transmit source when something else is reported. An event beats a simultaneous clear. Only the bench scenarios can show the visible results: the exact code sequence as sources stack up and are serviced in order, masking and later unmasking of a stored source, and arming of the transmit source from an enable write.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  // Source slots; the index equals the enable bit that gates the source.
  localparam int SRC_RX    = 0;
  localparam int SRC_TX    = 1;
  localparam int SRC_LINE  = 2;
  localparam int SRC_MODEM = 3;
  localparam int NUM_SRC   = 4;

  // Status bits 3:1 for each source.
  typedef enum logic [2:0] {
    CODE_MODEM = 3'b000,
    CODE_TX    = 3'b001,
    CODE_RX    = 3'b010,
    CODE_LINE  = 3'b011
  } irq_code_e;

  // Pick the winner among active sources; returns a one-hot grant.
  function automatic logic [NUM_SRC-1:0] rank_grant(input logic [NUM_SRC-1:0] act);
    logic [NUM_SRC-1:0] g;
    g = '0;
    if (act[SRC_LINE])       g[SRC_LINE]  = 1'b1;
    else if (act[SRC_RX])    g[SRC_RX]    = 1'b1;
    else if (act[SRC_TX])    g[SRC_TX]    = 1'b1;
    else if (act[SRC_MODEM]) g[SRC_MODEM] = 1'b1;
    return g;
  endfunction

  // Map a one-hot grant to the status byte.
  function automatic logic [7:0] status_of(input logic [NUM_SRC-1:0] g);
    irq_code_e c;
    c = CODE_MODEM;
    if (g[SRC_LINE])      c = CODE_LINE;
    else if (g[SRC_RX])   c = CODE_RX;
    else if (g[SRC_TX])   c = CODE_TX;
    return (g == '0) ? 8'h01 : {4'b0000, c, 1'b0};
  endfunction

endpackage

// File: rtl/irq_enable_reg.sv
module irq_enable_reg #(
  parameter int EN_BITS = 4,
  parameter int RD_W    = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr,
  input  logic [EN_BITS-1:0] wdata,
  output logic [EN_BITS-1:0] en_q,
  output logic [RD_W-1:0]    rdata,
  output logic               tx_en_rise
);
  localparam int PAD_W = RD_W - EN_BITS;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else if (wr) en_q <= wdata;
  end

  assign rdata      = {{PAD_W{1'b0}}, en_q};
  assign tx_en_rise = wr && wdata[uart_irq_pkg::SRC_TX] && !en_q[uart_irq_pkg::SRC_TX];

  assert_en_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> en_q == $past(wdata));
  assert_en_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(en_q));
endmodule

// File: rtl/irq_event_latch.sv
module irq_event_latch #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic         clr,
  output logic         pend,
  output logic         any_evt
);
  assign any_evt = |evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend <= 1'b0;
    else if (any_evt) pend <= 1'b1;
    else if (clr)     pend <= 1'b0;
  end

  assert_evt_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
    any_evt |=> pend);
  assert_clr_drops_R6_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !any_evt) |=> !pend);
endmodule

// File: rtl/irq_tx_arm.sv
module irq_tx_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_empty,
  input  logic en_rise,
  input  logic thr_wr,
  input  logic ack,
  output logic pend,
  output logic arm
);
  logic empty_q;

  // Reset to 1 so an idle, empty transmitter does not arm by itself.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) empty_q <= 1'b1;
    else        empty_q <= tx_empty;
  end

  assign arm = tx_empty && (!empty_q || en_rise);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              pend <= 1'b0;
    else if (arm)            pend <= 1'b1;
    else if (thr_wr || ack)  pend <= 1'b0;
  end

  assert_arm_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> pend);
  assert_thr_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_wr && !arm) |=> !pend);
  assert_ack_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !arm) |=> !pend);
endmodule

// File: rtl/irq_rank_enc.sv
module irq_rank_enc #(
  parameter int NS = uart_irq_pkg::NUM_SRC
) (
  input  logic [NS-1:0] act,
  output logic [NS-1:0] grant,
  output logic [7:0]    status
);
  always_comb begin
    grant  = uart_irq_pkg::rank_grant(act);
    status = uart_irq_pkg::status_of(grant);
  end

  always_comb begin
    assert_grant_onehot_R3: assert ($onehot0(grant));
  end
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio #(
  parameter int LINE_ERR_W = 4,
  parameter int MODEM_W    = 4,
  parameter int EN_BITS    = 4,
  parameter int REG_W      = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en_wr,
  input  logic [EN_BITS-1:0]    en_wdata,
  output logic [REG_W-1:0]      en_rdata,
  input  logic [LINE_ERR_W-1:0] line_err_evt,
  input  logic                  rx_full,
  input  logic                  tx_empty,
  input  logic [MODEM_W-1:0]    modem_delta_evt,
  input  logic                  isr_rd,
  input  logic                  lsr_rd,
  input  logic                  msr_rd,
  input  logic                  thr_wr,
  output logic [REG_W-1:0]      status,
  output logic                  irq
);
  import uart_irq_pkg::*;

  logic [EN_BITS-1:0] en_q;
  logic               tx_en_rise;
  logic               line_pend, line_evt;
  logic               modem_pend, modem_evt;
  logic               tx_pend, tx_arm, tx_ack;
  logic [NUM_SRC-1:0] pend_vec, act, grant;
  logic [7:0]         status_w;

  irq_enable_reg #(.EN_BITS(EN_BITS), .RD_W(REG_W)) u_en (
    .clk(clk), .rst_n(rst_n), .wr(en_wr), .wdata(en_wdata),
    .en_q(en_q), .rdata(en_rdata), .tx_en_rise(tx_en_rise));

  irq_event_latch #(.N(LINE_ERR_W)) u_line (
    .clk(clk), .rst_n(rst_n), .evt(line_err_evt), .clr(lsr_rd),
    .pend(line_pend), .any_evt(line_evt));

  irq_event_latch #(.N(MODEM_W)) u_modem (
    .clk(clk), .rst_n(rst_n), .evt(modem_delta_evt), .clr(msr_rd),
    .pend(modem_pend), .any_evt(modem_evt));

  // Status read acknowledges transmit-empty only when it is the reported source.
  assign tx_ack = isr_rd && grant[SRC_TX];

  irq_tx_arm u_tx (
    .clk(clk), .rst_n(rst_n), .tx_empty(tx_empty), .en_rise(tx_en_rise),
    .thr_wr(thr_wr), .ack(tx_ack), .pend(tx_pend), .arm(tx_arm));

  always_comb begin
    pend_vec            = '0;
    pend_vec[SRC_RX]    = rx_full;
    pend_vec[SRC_TX]    = tx_pend;
    pend_vec[SRC_LINE]  = line_pend;
    pend_vec[SRC_MODEM] = modem_pend;
  end

  assign act = pend_vec & en_q[NUM_SRC-1:0];

  irq_rank_enc #(.NS(NUM_SRC)) u_rank (.act(act), .grant(grant), .status(status_w));

  assign status = {{(REG_W-8){1'b0}}, status_w};
  assign irq    = ~status_w[0];

  assert_status_hi_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    status[7:4] == 4'b0000);
  assert_irq_tracks_act_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (act != '0));
  assert_line_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    act[SRC_LINE] |-> status[3:0] == 4'b0110);
  assert_spare_tx_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (isr_rd && !grant[SRC_TX] && tx_pend && !thr_wr) |=> tx_pend);
  assert_rd_keeps_line_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (line_pend && !lsr_rd) |=> line_pend);
endmodule

// File: tb/uart_irq_prio_test.sv
`timescale 1ns/1ps
module uart_irq_prio_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en_wr = 1'b0;
  logic [3:0] en_wdata = '0;
  logic [7:0] en_rdata;
  logic [3:0] line_err_evt = '0;
  logic       rx_full = 1'b0;
  logic       tx_empty = 1'b1;
  logic [3:0] modem_delta_evt = '0;
  logic       isr_rd = 1'b0, lsr_rd = 1'b0, msr_rd = 1'b0, thr_wr = 1'b0;
  logic [7:0] status;
  logic       irq;

  int checks = 0;
  int fails  = 0;
  logic [7:0] exp_st_q[$];
  logic [7:0] exp_en_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  uart_irq_prio uut (
    .clk(clk), .rst_n(rst_n), .en_wr(en_wr), .en_wdata(en_wdata), .en_rdata(en_rdata),
    .line_err_evt(line_err_evt), .rx_full(rx_full), .tx_empty(tx_empty),
    .modem_delta_evt(modem_delta_evt), .isr_rd(isr_rd), .lsr_rd(lsr_rd),
    .msr_rd(msr_rd), .thr_wr(thr_wr), .status(status), .irq(irq));

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  // Monitor: pops expectations and compares against the ports.
  initial begin
    forever begin
      wait (exp_st_q.size() != 0);
      begin
        logic [7:0] es, ee;
        string t;
        es = exp_st_q.pop_front();
        ee = exp_en_q.pop_front();
        t  = tag_q.pop_front();
        checks++;
        if (status !== es) begin
          fails++;
          $display("FAIL %s status act=%02h exp=%02h", t, status, es);
        end
        checks++;
        if (irq !== ~es[0]) begin
          fails++;
          $display("FAIL %s/R11 irq act=%b exp=%b", t, irq, ~es[0]);
        end
        checks++;
        if (en_rdata !== ee) begin
          fails++;
          $display("FAIL %s enable readback act=%02h exp=%02h", t, en_rdata, ee);
        end
      end
    end
  end

  // Driver helpers.
  logic [7:0] en_model = 8'h00;

  task automatic expect_st(input logic [7:0] st, input string t);
    exp_st_q.push_back(st);
    exp_en_q.push_back(en_model);
    tag_q.push_back(t);
    #1;
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
    en_wr = 1'b0; line_err_evt = '0; modem_delta_evt = '0;
    isr_rd = 1'b0; lsr_rd = 1'b0; msr_rd = 1'b0; thr_wr = 1'b0;
  endtask

  task automatic write_en(input logic [3:0] v);
    @(negedge clk);
    en_wr = 1'b1; en_wdata = v;
    en_model = {4'b0000, v};
    cyc();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1 expect_st(8'h01, "R1");

    // R2 / R8: write all ones; only four bits stored; transmit arms from enable edge.
    write_en(4'hF);
    expect_st(8'h02, "R2/R8");

    // R8: transmit holding write drops it.
    @(negedge clk); thr_wr = 1'b1; tx_empty = 1'b0; cyc();
    expect_st(8'h01, "R8");
    @(negedge clk); tx_empty = 1'b1; cyc();
    expect_st(8'h02, "R8");

    // R9: status read while transmit is reported acknowledges it.
    @(negedge clk); isr_rd = 1'b1; cyc();
    expect_st(8'h01, "R9");

    // R3: stack sources lowest first.
    @(negedge clk); tx_empty = 1'b0; cyc();
    @(negedge clk); tx_empty = 1'b1; cyc();
    expect_st(8'h02, "R8");
    @(negedge clk); modem_delta_evt = 4'b0100; cyc();
    expect_st(8'h02, "R3");
    @(negedge clk); rx_full = 1'b1; cyc();
    expect_st(8'h04, "R3/R7");
    @(negedge clk); line_err_evt = 4'b0010; cyc();
    expect_st(8'h06, "R3/R6");

    // R6 / R9: status read with line reported clears neither line nor transmit.
    @(negedge clk); isr_rd = 1'b1; cyc();
    expect_st(8'h06, "R6/R9");
    @(negedge clk); lsr_rd = 1'b1; cyc();
    expect_st(8'h04, "R6");
    @(negedge clk); rx_full = 1'b0; cyc();
    expect_st(8'h02, "R7/R9");
    @(negedge clk); isr_rd = 1'b1; cyc();
    expect_st(8'h00, "R3/R9");
    @(negedge clk); isr_rd = 1'b1; cyc();
    expect_st(8'h00, "R10");
    @(negedge clk); msr_rd = 1'b1; cyc();
    expect_st(8'h01, "R10/R4");

    // R5: modem change while masked is kept and shows once enabled.
    write_en(4'h0);
    @(negedge clk); modem_delta_evt = 4'b0001; cyc();
    expect_st(8'h01, "R5");
    write_en(4'h8);
    expect_st(8'h00, "R5");
    @(negedge clk); msr_rd = 1'b1; cyc();
    expect_st(8'h01, "R10");

    // R12: line event and line-status read together.
    write_en(4'h4);
    @(negedge clk); lsr_rd = 1'b1; line_err_evt = 4'b1000; cyc();
    expect_st(8'h06, "R12");
    @(negedge clk); lsr_rd = 1'b1; cyc();
    expect_st(8'h01, "R6");

    // R8: enable write setting bit 1 while empty arms the transmit source.
    write_en(4'hF);
    expect_st(8'h02, "R8");
    @(negedge clk); thr_wr = 1'b1; cyc();
    expect_st(8'h01, "R8");

    // R5 / R7: receive masked by enable bit 0.
    write_en(4'hE);
    @(negedge clk); rx_full = 1'b1; cyc();
    expect_st(8'h01, "R5/R7");
    write_en(4'hF);
    expect_st(8'h04, "R7");

    repeat (4) @(posedge clk);
    summary();
    $finish;
  end
endmodule